// File: doc/BRIEF.md
# ADC Scan Sequencer with Qualified Trigger

This block is the control sequencer that sits in front of an analog-to-digital converter core. The core itself is abstracted behind a small request stream: the sequencer offers a channel number, the core accepts it, and some cycles later it returns a one-cycle completion pulse. The sequencer decides which channel comes next, when a pass through the channel list is finished, and whether to go again.

Conversions are started by a software start request or by an external trigger pin. The pin is synchronised and then qualified as a low level, a high level, a falling edge or a rising edge, with minimum hold times that reject short glitches. Three operating modes are supported: one conversion of the first list slot, one pass over the list, or repeated passes until software stops the sequencer. The channel order comes from a 32-bit list of eight 4-bit slots. The operating mode and the list are captured when a start is accepted and stay fixed until the sequencer is idle again. Status consists of a busy bit (the start bit), the channel most recently handed to the core, and a sticky end-of-conversion flag with an interrupt enable.

The request interface follows valid/ready rules. `conv_valid` is never withdrawn and `conv_chan` never changes while the request waits for `conv_ready`. The core may hold `conv_ready` low for any number of cycles. `conv_done` is honoured only while a conversion is outstanding.

Top module: `adc_scan_seq`

## Requirements
- R1: The `scan_mode` codes are 2'b00 single conversion, 2'b10 one pass, 2'b11 continuous, and 2'b01 reserved. A start request made while the mode is 2'b01 is ignored: no request is issued and `busy` stays 0.
- R2: In single mode, exactly one conversion is made, on the channel held in slot 0 (`chan_list[3:0]`, channel = low 3 bits). Afterwards `busy` returns to 0 and `eoc` is set.
- R3: In one-pass mode, slots are converted in order from slot 0 (`chan_list[3:0]`) up to slot 7 (`chan_list[31:28]`). The pass stops before the first slot that holds 4'b1001, or after slot 7. Then `busy` clears and `eoc` sets.
- R4: In continuous mode, passes repeat until `sw_stop` is pulsed. The conversion in flight at that moment still completes, no further request follows, and `eoc` sets at the end of each completed pass.
- R5: If slot 0 holds 4'b1001 in any scan mode, no request is issued, `busy` drops back to 0 at once, and `eoc` is unchanged.
- R6: `eoc` is cleared by a pulse on `eoc_clr`. `irq` equals `eoc` AND `irq_en`.
- R7: The pin starts a conversion only when `trig_en` is 1. `trig_cond` codes are 2'b00 low level, 2'b01 high level, 2'b10 falling edge and 2'b11 rising edge. A level is accepted only after the pin has held it for 8 clocks; 7 clocks do not start anything.
- R8: An edge is accepted only if the pin held its old level for at least 4 clocks and then holds its new level for 4 clocks. A hold of 3 clocks on either side starts nothing.
- R9: `busy` rises when a start is accepted and falls immediately on `sw_stop`. `cur_chan` holds the channel of the most recently accepted request.
- R10: No start is accepted while `conv_en` is 0.
- R11: Once raised, `conv_valid` stays high with `conv_chan` stable until `conv_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_en | input | 1 | Converter enable; starts are refused when 0 |
| scan_mode | input | 2 | Operating mode code |
| chan_list | input | 32 | Eight 4-bit channel slots, slot 0 in the low bits |
| sw_go | input | 1 | Software start request pulse |
| sw_stop | input | 1 | Software pulse that clears the start bit |
| trig_en | input | 1 | External trigger enable |
| trig_cond | input | 2 | Trigger qualification code |
| trig_pin | input | 1 | External trigger pin (asynchronous) |
| eoc_clr | input | 1 | Clear pulse for the end-of-conversion flag |
| irq_en | input | 1 | Interrupt enable |
| busy | output | 1 | Start bit / busy status |
| cur_chan | output | 3 | Channel of the most recent request |
| eoc | output | 1 | Sticky end-of-conversion flag |
| irq | output | 1 | Interrupt request |
| conv_valid | output | 1 | Conversion request valid |
| conv_ready | input | 1 | Converter accepts the request |
| conv_chan | output | 3 | Channel of the request |
| conv_done | input | 1 | One-cycle conversion complete pulse |

## Verification
The bench builds the block with its defaults: eight slots, a level hold of 8 clocks, an edge hold of 4 clocks and a two-stage synchroniser. With these values every terminator position from slot 0 through "no terminator" can be swept for one-pass mode across several channel patterns, and every one of the eight channels can be swept in single mode. Each hold threshold is tested one clock below its limit and exactly at its limit. The converter model stalls `conv_ready` on every third cycle, so the request-hold rule is exercised on every run.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SLOT_W = 4;
  localparam int CH_W   = 3;
  localparam logic [SLOT_W-1:0] SLOT_END = 4'b1001;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_ONCE   = 2'b10,
    MODE_LOOP   = 2'b11
  } scan_mode_e;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_cond_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10
  } seq_state_e;
endpackage

// File: rtl/adc_trig_qual.sv
module adc_trig_qual
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_MIN   = 8,
  parameter int EDGE_MIN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       en,
  input  logic [1:0] cond,
  output logic       fire
);
  localparam int RUN_MAX = (LEVEL_MIN > EDGE_MIN) ? LEVEL_MIN : EDGE_MIN;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   s;
  logic                   lvl_q;
  logic [RUN_W-1:0]       run_q;
  logic                   prev_ok_q;

  // synchroniser chain; s is the clean copy of the pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
  end
  assign s = sync_q[SYNC_STAGES-1];

  // run length of the current level, plus whether the previous run was long enough
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q     <= 1'b0;
      run_q     <= '0;
      prev_ok_q <= 1'b0;
    end else if (s != lvl_q) begin
      lvl_q     <= s;
      prev_ok_q <= (run_q >= RUN_W'(EDGE_MIN));
      run_q     <= RUN_W'(1);
    end else if (run_q != RUN_W'(RUN_MAX)) begin
      run_q <= run_q + 1'b1;
    end
  end

  trig_cond_e c;
  logic       target;
  logic       level_hit;
  logic       edge_hit;
  assign c         = trig_cond_e'(cond);
  assign target    = cond[0];
  assign level_hit = (lvl_q == target) && (run_q >= RUN_W'(LEVEL_MIN));
  assign edge_hit  = (s == lvl_q) && (lvl_q == target) && prev_ok_q &&
                     (run_q == RUN_W'(EDGE_MIN - 1));

  always_comb begin
    fire = 1'b0;
    if (en) begin
      case (c)
        TRIG_LOW, TRIG_HIGH: fire = level_hit;
        default:             fire = edge_hit;
      endcase
    end
  end

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cond[1]) |-> ($past(s) == cond[0])); // R7
  AST_EDGE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cond[1]) |-> ((s == cond[0]) && ($past(s) == cond[0]))); // R8
endmodule

// File: rtl/adc_slot_sel.sv
module adc_slot_sel
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int IW        = 3
) (
  input  logic [NUM_SLOTS*SLOT_W-1:0] list,
  input  logic [IW-1:0]               idx,
  output logic [CH_W-1:0]             chan,
  output logic                        cur_end,
  output logic                        nxt_end
);
  logic [SLOT_W-1:0] slots [NUM_SLOTS];
  logic [SLOT_W-1:0] code;
  logic [SLOT_W-1:0] code_nxt;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slots[g] = list[g*SLOT_W +: SLOT_W];
  end

  // current slot and the slot after it; past the last slot reads as terminator
  always_comb begin
    code     = SLOT_END;
    code_nxt = SLOT_END;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (idx == IW'(k)) code = slots[k];
      if (k > 0 && idx == IW'(k - 1)) code_nxt = slots[k];
    end
  end

  assign chan    = code[CH_W-1:0];
  assign cur_end = (code == SLOT_END);
  assign nxt_end = (code_nxt == SLOT_END);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        conv_en,
  input  logic [1:0]                  mode_in,
  input  logic [NUM_SLOTS*SLOT_W-1:0] list_in,
  input  logic                        go,
  input  logic                        stop,
  input  logic                        eoc_clr,
  input  logic                        irq_en,
  output logic                        busy,
  output logic [CH_W-1:0]             cur_chan,
  output logic                        eoc,
  output logic                        irq,
  output logic                        conv_valid,
  input  logic                        conv_ready,
  output logic [CH_W-1:0]             conv_chan,
  input  logic                        conv_done
);
  localparam int IDX_W  = $clog2(NUM_SLOTS);
  localparam int LIST_W = NUM_SLOTS * SLOT_W;

  seq_state_e        state_q;
  scan_mode_e        mode_q;
  logic [LIST_W-1:0] list_q;
  logic [IDX_W-1:0]  idx_q;
  logic              start_q;
  logic              eoc_q;
  logic [CH_W-1:0]   chan_q;

  logic [CH_W-1:0]   slot_chan;
  logic              cur_end;
  logic              nxt_end;

  adc_slot_sel #(.NUM_SLOTS(NUM_SLOTS), .IW(IDX_W)) u_sel (
    .list    (list_q),
    .idx     (idx_q),
    .chan    (slot_chan),
    .cur_end (cur_end),
    .nxt_end (nxt_end)
  );

  logic accept;
  logic pass_end;
  logic set_eoc;
  assign accept   = go && conv_en && (state_q == ST_IDLE) && !start_q &&
                    (scan_mode_e'(mode_in) != MODE_RSVD);
  assign pass_end = (mode_q == MODE_SINGLE) || nxt_end;
  assign set_eoc  = (state_q == ST_WAIT) && conv_done && pass_end;

  assign conv_valid = (state_q == ST_ISSUE) && !cur_end;
  assign conv_chan  = slot_chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_SINGLE;
      list_q  <= '0;
      idx_q   <= '0;
      start_q <= 1'b0;
      chan_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            start_q <= 1'b1;
            mode_q  <= scan_mode_e'(mode_in);
            list_q  <= list_in;
            idx_q   <= '0;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (cur_end) begin
            start_q <= 1'b0;
            state_q <= ST_IDLE;
          end else if (conv_ready) begin
            chan_q  <= slot_chan;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (conv_done) begin
            if (pass_end) begin
              if (mode_q == MODE_LOOP && start_q && !stop) begin
                idx_q   <= '0;
                state_q <= ST_ISSUE;
              end else begin
                start_q <= 1'b0;
                state_q <= ST_IDLE;
              end
            end else if (!start_q || stop) begin
              start_q <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (stop) start_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       eoc_q <= 1'b0;
    else if (set_eoc) eoc_q <= 1'b1;
    else if (eoc_clr) eoc_q <= 1'b0;
  end

  assign busy     = start_q;
  assign cur_chan = chan_q;
  assign eoc      = eoc_q;
  assign irq      = eoc_q && irq_en;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !conv_ready) |=> (conv_valid && $stable(conv_chan))); // R11
  AST_EOC_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> $past(conv_done)); // R6
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(conv_en)); // R10
  AST_SINGLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && mode_q == MODE_SINGLE && conv_done) |=> !busy); // R2
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_MIN   = 8,
  parameter int EDGE_MIN    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        conv_en,
  input  logic [1:0]                  scan_mode,
  input  logic [NUM_SLOTS*SLOT_W-1:0] chan_list,
  input  logic                        sw_go,
  input  logic                        sw_stop,
  input  logic                        trig_en,
  input  logic [1:0]                  trig_cond,
  input  logic                        trig_pin,
  input  logic                        eoc_clr,
  input  logic                        irq_en,
  output logic                        busy,
  output logic [CH_W-1:0]             cur_chan,
  output logic                        eoc,
  output logic                        irq,
  output logic                        conv_valid,
  input  logic                        conv_ready,
  output logic [CH_W-1:0]             conv_chan,
  input  logic                        conv_done
);
  logic trig_fire;

  adc_trig_qual #(
    .SYNC_STAGES (SYNC_STAGES),
    .LEVEL_MIN   (LEVEL_MIN),
    .EDGE_MIN    (EDGE_MIN)
  ) u_trig (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (trig_pin),
    .en   (trig_en),
    .cond (trig_cond),
    .fire (trig_fire)
  );

  adc_seq_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_en   (conv_en),
    .mode_in   (scan_mode),
    .list_in   (chan_list),
    .go        (sw_go || trig_fire),
    .stop      (sw_stop),
    .eoc_clr   (eoc_clr),
    .irq_en    (irq_en),
    .busy      (busy),
    .cur_chan  (cur_chan),
    .eoc       (eoc),
    .irq       (irq),
    .conv_valid(conv_valid),
    .conv_ready(conv_ready),
    .conv_chan (conv_chan),
    .conv_done (conv_done)
  );
endmodule

// File: tb/adc_scan_seq_bench.sv
`timescale 1ns/1ps
module adc_scan_seq_bench;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_en = 1'b1;
  logic [1:0]  scan_mode = 2'b00;
  logic [31:0] chan_list = '0;
  logic        sw_go = 1'b0, sw_stop = 1'b0;
  logic        trig_en = 1'b0;
  logic [1:0]  trig_cond = 2'b01;
  logic        trig_pin = 1'b0;
  logic        eoc_clr = 1'b0, irq_en = 1'b0;
  logic        busy, eoc, irq, conv_valid;
  logic [2:0]  cur_chan, conv_chan;
  logic        conv_ready = 1'b0, conv_done = 1'b0;

  int checks = 0, failures = 0;
  int log_n = 0;
  logic [2:0] log_ch [64];
  int pend = 0;
  int rdy_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .scan_mode(scan_mode),
    .chan_list(chan_list), .sw_go(sw_go), .sw_stop(sw_stop), .trig_en(trig_en),
    .trig_cond(trig_cond), .trig_pin(trig_pin), .eoc_clr(eoc_clr), .irq_en(irq_en),
    .busy(busy), .cur_chan(cur_chan), .eoc(eoc), .irq(irq), .conv_valid(conv_valid),
    .conv_ready(conv_ready), .conv_chan(conv_chan), .conv_done(conv_done)
  );

  // converter model: logs accepted channels, answers after LAT cycles
  always @(posedge clk) begin
    if (rst_n && conv_valid && conv_ready) begin
      if (log_n < 64) log_ch[log_n] = conv_chan;
      log_n = log_n + 1;
      pend = LAT;
    end
  end
  always @(negedge clk) begin
    rdy_cnt = rdy_cnt + 1;
    conv_ready = (rdy_cnt % 3) != 0;
    conv_done = 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) conv_done = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_go();
    @(negedge clk) sw_go = 1'b1;
    @(negedge clk) sw_go = 1'b0;
  endtask

  task automatic clr_eoc();
    @(negedge clk) eoc_clr = 1'b1;
    @(negedge clk) eoc_clr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busy && pend == 0 && !conv_valid) break;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic pin_pulse(input logic lvl, input int len);
    @(negedge clk) trig_pin = lvl;
    repeat (len - 1) @(negedge clk);
    @(negedge clk) trig_pin = ~lvl;
    repeat (40) @(negedge clk);
    wait_idle();
  endtask

  task automatic arm_trig(input logic idle_lvl, input logic [1:0] cnd);
    @(negedge clk) trig_en = 1'b0;
    trig_pin = idle_lvl;
    repeat (20) @(negedge clk);
    trig_cond = cnd;
    trig_en = 1'b1;
    log_n = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(!busy && !eoc && !irq && !conv_valid && cur_chan == 0, "R9 reset", {busy, eoc, irq, conv_valid}, 0);

    // R2: single mode, every channel in slot 0
    for (int c = 0; c < 8; c++) begin
      scan_mode = 2'b00;
      chan_list = {28'h7654321, 4'(c)};
      irq_en = c[0];
      clr_eoc();
      log_n = 0;
      pulse_go();
      wait_idle();
      chk(log_n == 1, "R2 count", log_n, 1);
      chk(log_ch[0] == 3'(c), "R2 chan", log_ch[0], c);
      chk(eoc == 1'b1 && !busy, "R2 eoc/busy", {eoc, busy}, 2);
      chk(irq == c[0], "R6 irq", irq, c[0]);
      chk(cur_chan == 3'(c), "R9 cur_chan", cur_chan, c);
    end
    clr_eoc();
    @(negedge clk);
    chk(!eoc && !irq, "R6 clear", {eoc, irq}, 0);

    // R3 / R5: one pass, terminator at every position
    for (int seed = 0; seed < 3; seed++) begin
      for (int p = 0; p <= 8; p++) begin
        logic [31:0] l;
        for (int i = 0; i < 8; i++) begin
          if (i < p)       l[i*4 +: 4] = 4'((i*5 + seed*3 + 1) % 8);
          else if (i == p) l[i*4 +: 4] = 4'b1001;
          else             l[i*4 +: 4] = 4'((i + seed) % 8);
        end
        scan_mode = 2'b10;
        chan_list = l;
        clr_eoc();
        log_n = 0;
        pulse_go();
        wait_idle();
        chk(log_n == p, (p == 0) ? "R5 count" : "R3 count", log_n, p);
        for (int i = 0; i < p; i++)
          chk(log_ch[i] == 3'((i*5 + seed*3 + 1) % 8), "R3 order", log_ch[i], (i*5 + seed*3 + 1) % 8);
        chk(eoc == (p > 0), (p == 0) ? "R5 eoc" : "R3 eoc", eoc, p > 0);
        chk(!busy, "R3 busy", busy, 0);
      end
    end

    // R9: busy rises on accept
    scan_mode = 2'b10;
    chan_list = 32'h9000_0123;
    pulse_go();
    chk(busy == 1'b1, "R9 busy rise", busy, 1);
    wait_idle();

    // R1: reserved mode
    scan_mode = 2'b01;
    log_n = 0;
    pulse_go();
    @(negedge clk);
    chk(!busy, "R1 busy", busy, 0);
    wait_idle();
    chk(log_n == 0, "R1 count", log_n, 0);

    // R10: converter disabled
    scan_mode = 2'b10;
    conv_en = 1'b0;
    log_n = 0;
    pulse_go();
    wait_idle();
    chk(log_n == 0 && !busy, "R10 count", log_n, 0);
    conv_en = 1'b1;

    // R4: continuous, three-slot list
    scan_mode = 2'b11;
    chan_list = 32'h0000_9416;
    clr_eoc();
    log_n = 0;
    pulse_go();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (log_n >= 7) break;
    end
    sw_stop = 1'b1;
    @(negedge clk) sw_stop = 1'b0;
    chk(!busy, "R9 busy on stop", busy, 0);
    wait_idle();
    chk(log_n == 7, "R4 count", log_n, 7);
    for (int i = 0; i < 7; i++) begin
      int e;
      e = (i % 3 == 0) ? 6 : ((i % 3 == 1) ? 1 : 4);
      chk(log_ch[i] == 3'(e), "R4 order", log_ch[i], e);
    end
    chk(eoc == 1'b1, "R4 eoc", eoc, 1);

    // triggers, single mode on channel 3
    scan_mode = 2'b00;
    chan_list = 32'h0000_0003;
    arm_trig(1'b0, 2'b01);
    pin_pulse(1'b1, 7);
    chk(log_n == 0, "R7 high 7", log_n, 0);
    pin_pulse(1'b1, 8);
    chk(log_n == 1, "R7 high 8", log_n, 1);
    arm_trig(1'b1, 2'b00);
    pin_pulse(1'b0, 7);
    chk(log_n == 0, "R7 low 7", log_n, 0);
    pin_pulse(1'b0, 8);
    chk(log_n == 1, "R7 low 8", log_n, 1);
    arm_trig(1'b0, 2'b11);
    pin_pulse(1'b1, 3);
    chk(log_n == 0, "R8 rise high 3", log_n, 0);
    pin_pulse(1'b1, 4);
    chk(log_n == 1, "R8 rise high 4", log_n, 1);
    arm_trig(1'b1, 2'b11);
    pin_pulse(1'b0, 3);
    chk(log_n == 0, "R8 rise low 3", log_n, 0);
    arm_trig(1'b1, 2'b10);
    pin_pulse(1'b0, 3);
    chk(log_n == 0, "R8 fall low 3", log_n, 0);
    pin_pulse(1'b0, 4);
    chk(log_n == 1, "R8 fall low 4", log_n, 1);
    arm_trig(1'b0, 2'b01);
    trig_en = 1'b0;
    pin_pulse(1'b1, 20);
    chk(log_n == 0, "R7 disabled", log_n, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule